// File: doc/BRIEF.md
# Configuration Ring Distributor

The block pushes already-decoded control values for the next layer out to a set of kernel stations while the current layer is still running. A small reader fetches configuration words from a local buffer with a one-cycle read latency. It places them, one after another, on a one-way chain of stations and closes the sequence with an end marker. Each word names a destination station and a field slot. Every station forwards every word one hop per register stage and copies the words aimed at itself into shadow storage.

Delivery is complete when the end marker leaves the last station. A layer sequencer reports the end of the running layer with a pulse. Once both events have been seen, in either order or in the same cycle, the block issues a single apply pulse. That pulse moves every shadow field into the active registers the kernels use, so the kernels change configuration at one clean layer boundary. Any station can hold off the words arriving at it, and the stall then backs up the chain to the reader. More kernels are added by lengthening the chain; the reader stays the same.

Top module: `cfg_ring_dist`

## Requirements
- R1: After reset, `act_cfg` is all zero, and `apply`, `cfg_busy`, `cfg_done` and `mem_rd_en` are low.
- R2: A `start` pulse while idle reads buffer addresses 0 to `cfg_len`-1, each exactly once and in increasing order. The data appears on `mem_rd_data` in the cycle after the read. At most one read is issued in any two consecutive cycles.
- R3: A word is 23 bits: bit 22 is the end marker, bits 21:18 the station ID, bits 17:16 the field index and bits 15:0 the value. A word with the marker clear and an ID below `N_STN` is stored in field f of station s. After the next apply it shows on `act_cfg[(s*4+f)*16 +: 16]`. When several words hit the same field, the one read last wins.
- R4: `act_cfg` changes only in a cycle in which `apply` is high. Delivered values stay invisible until then.
- R5: `apply` is a one-cycle pulse. It is high in the cycle after the later of two events: the end marker leaving the tail, and a `layer_done` pulse. The two events may come in either order or in the same cycle. In the same-cycle case `cfg_done` is never seen high.
- R6: `cfg_busy` is high from the cycle after an accepted `start` until `apply`. `cfg_done` is high from the cycle after the end marker leaves the tail until `apply`. Both are low in the `apply` cycle.
- R7: While a station's `stn_hold` bit is high, no word enters that station and the reader stops reading once its output slot is full. No word is lost or duplicated, and the final contents match an unstalled run.
- R8: A word whose ID is `N_STN` or above travels the whole chain and is discarded at the tail. It changes no field of any station.
- R9: A `start` while `cfg_busy` is high is ignored, and the running transfer keeps its original length.
- R10: With `cfg_len` = 0 only the end marker is sent, no buffer read takes place, and the following apply leaves `act_cfg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin distributing a new configuration |
| cfg_len | input | ADDR_W+1 | Number of words to read, sampled on start |
| cfg_busy | output | 1 | Transfer in progress or awaiting apply |
| cfg_done | output | 1 | All words delivered, waiting for layer end |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_rd_addr | output | ADDR_W | Buffer read address |
| mem_rd_data | input | 23 | Buffer read data, one cycle after the strobe |
| layer_done | input | 1 | Pulse: current layer finished |
| stn_hold | input | N_STN | Per-station hold: station cannot accept a word |
| apply | output | 1 | Pulse: shadow fields copied into active fields |
| act_cfg | output | N_STN*64 | Active fields, station-major, 4 fields of 16 bits |

## Verification
The delicate coincidence is the end marker leaving the tail in the same cycle as the `layer_done` pulse. A delivery flag that set and cleared in the wrong order would then either lose the apply or leave a stale done. The bench first measures how many cycles an unstalled transfer takes from `start` until `cfg_done` rises. It then repeats an identical transfer with `layer_done` placed one cycle earlier, so that it coincides with the marker leaving the tail. It expects `apply` exactly where `cfg_done` would have risen, with `cfg_done` never high and the new values in place.

// File: rtl/cfg_ring_pkg.sv
// Shared word format for the configuration ring.
// Assumes fixed field widths; the station count is a top-level parameter.
package cfg_ring_pkg;
    localparam int unsigned ID_W   = 4;
    localparam int unsigned FLD_W  = 2;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned N_FLD  = 1 << FLD_W;

    typedef struct packed {
        logic              eop;
        logic [ID_W-1:0]   id;
        logic [FLD_W-1:0]  fld;
        logic [DATA_W-1:0] data;
    } cfg_word_t;

    localparam int unsigned WORD_W = $bits(cfg_word_t);
endpackage

// File: rtl/cfg_reader.sv
// Reader: fetches cfg_len words from the buffer (one-cycle read latency),
// offers them to the ring head one at a time and then appends the end marker.
// Assumes the buffer answers every read in the next cycle. The reader stays
// busy until released by the apply decision.
module cfg_reader
    import cfg_ring_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   len,
    input  logic              release_i,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              out_valid,
    output cfg_word_t         out_word,
    input  logic              out_ready
);
    typedef enum logic [1:0] {R_IDLE, R_DATA, R_EOP, R_WAIT} rd_state_t;

    rd_state_t   st_q;
    logic [ADDR_W:0] cnt_q, len_q;
    logic        pend_q;
    logic        ov_q;
    cfg_word_t   ow_q;
    logic        issue;

    // Read only when no read is in flight and the output slot will be free.
    assign issue = (st_q == R_DATA) && !pend_q && (cnt_q < len_q) && (!ov_q || out_ready);

    assign mem_rd_en   = issue;
    assign mem_rd_addr = cnt_q[ADDR_W-1:0];
    assign out_valid   = ov_q;
    assign out_word    = ow_q;
    assign busy        = (st_q != R_IDLE);

    // Sequencing of reads, output slot and end marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= R_IDLE;
            cnt_q  <= '0;
            len_q  <= '0;
            pend_q <= 1'b0;
            ov_q   <= 1'b0;
            ow_q   <= '0;
        end else begin
            pend_q <= issue;
            if (issue) cnt_q <= cnt_q + 1'b1;
            if (pend_q) begin
                ov_q <= 1'b1;
                ow_q <= cfg_word_t'(mem_rd_data);
            end else if (ov_q && out_ready) begin
                ov_q <= 1'b0;
            end
            case (st_q)
                R_IDLE: if (start) begin
                    len_q <= len;
                    cnt_q <= '0;
                    st_q  <= (len == '0) ? R_EOP : R_DATA;
                end
                R_DATA: if ((cnt_q == len_q) && !pend_q) st_q <= R_EOP;
                R_EOP: if (!ov_q || out_ready) begin
                    ov_q     <= 1'b1;
                    ow_q.eop <= 1'b1;
                    ow_q.id  <= '1;
                    ow_q.fld <= '0;
                    ow_q.data <= '0;
                    st_q     <= R_WAIT;
                end
                R_WAIT: if (release_i) st_q <= R_IDLE;
                default: st_q <= R_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_station.sv
// Ring station: one register stage per hop with valid/ready. It forwards
// every word unchanged and captures matching words into shadow fields;
// apply copies the shadow fields to the active fields.
// Assumes apply never coincides with a capture it must include.
module cfg_station
    import cfg_ring_pkg::*;
#(
    parameter int unsigned MY_ID = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  cfg_word_t               in_word,
    output logic                    in_ready,
    output logic                    out_valid,
    output cfg_word_t               out_word,
    input  logic                    out_ready,
    input  logic                    hold,
    input  logic                    apply,
    output logic [N_FLD*DATA_W-1:0] act_cfg
);
    logic        v_q;
    cfg_word_t   w_q;
    logic [DATA_W-1:0] sh_q  [N_FLD];
    logic [DATA_W-1:0] act_q [N_FLD];
    logic        hit;

    assign in_ready  = !hold && (!v_q || out_ready);
    assign out_valid = v_q;
    assign out_word  = w_q;
    assign hit = in_valid && in_ready && !in_word.eop && (in_word.id == ID_W'(MY_ID));

    // Hop register: take a new word when allowed, otherwise drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            w_q <= '0;
        end else if (in_ready) begin
            v_q <= in_valid;
            w_q <= in_word;
        end else if (out_ready) begin
            v_q <= 1'b0;
        end
    end

    // Shadow capture and active update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < N_FLD; f++) begin
                sh_q[f]  <= '0;
                act_q[f] <= '0;
            end
        end else begin
            if (hit) sh_q[in_word.fld] <= in_word.data;
            if (apply) begin
                for (int f = 0; f < N_FLD; f++) act_q[f] <= sh_q[f];
            end
        end
    end

    // Pack the active fields, field 0 in the low bits.
    always_comb begin
        for (int f = 0; f < N_FLD; f++) act_cfg[f*DATA_W +: DATA_W] = act_q[f];
    end
endmodule

// File: rtl/cfg_apply_ctl.sv
// Apply control: remembers delivery completion and layer end, and decides
// the apply once both are known (either order or the same cycle).
// Assumes eop_tail and layer_done are single-cycle events.
module cfg_apply_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic eop_tail,
    input  logic layer_done,
    output logic go,
    output logic apply,
    output logic cfg_done
);
    logic dlv_q, lay_q, apply_q;

    assign go       = (dlv_q || eop_tail) && (lay_q || layer_done);
    assign apply    = apply_q;
    assign cfg_done = dlv_q;

    // Event latches cleared by the apply decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_q   <= 1'b0;
            lay_q   <= 1'b0;
            apply_q <= 1'b0;
        end else begin
            apply_q <= go;
            dlv_q   <= go ? 1'b0 : (dlv_q || eop_tail);
            lay_q   <= go ? 1'b0 : (lay_q || layer_done);
        end
    end
endmodule

// File: rtl/cfg_ring_dist.sv
// Top: reader, a chain of N_STN stations and the apply control.
// Assumes N_STN is below 15 so the end-marker ID never names a station.
module cfg_ring_dist
    import cfg_ring_pkg::*;
#(
    parameter int unsigned N_STN  = 4,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [ADDR_W:0]               cfg_len,
    output logic                          cfg_busy,
    output logic                          cfg_done,
    output logic                          mem_rd_en,
    output logic [ADDR_W-1:0]             mem_rd_addr,
    input  logic [WORD_W-1:0]             mem_rd_data,
    input  logic                          layer_done,
    input  logic [N_STN-1:0]              stn_hold,
    output logic                          apply,
    output logic [N_STN*N_FLD*DATA_W-1:0] act_cfg
);
    localparam int unsigned ST_W = N_FLD * DATA_W;

    cfg_word_t  link_w [N_STN+1];
    logic [N_STN:0] link_v, link_r;
    logic go, eop_tail;
    logic unused_tail;

    cfg_reader #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .start(start), .len(cfg_len),
        .release_i(go), .busy(cfg_busy),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .out_valid(link_v[0]), .out_word(link_w[0]), .out_ready(link_r[0])
    );

    for (genvar s = 0; s < N_STN; s++) begin : g_stn
        cfg_station #(.MY_ID(s)) u_st (
            .clk(clk), .rst_n(rst_n),
            .in_valid(link_v[s]), .in_word(link_w[s]), .in_ready(link_r[s]),
            .out_valid(link_v[s+1]), .out_word(link_w[s+1]), .out_ready(link_r[s+1]),
            .hold(stn_hold[s]), .apply(go),
            .act_cfg(act_cfg[s*ST_W +: ST_W])
        );
    end

    // The tail always drains; only the end marker matters there.
    assign link_r[N_STN] = 1'b1;
    assign eop_tail      = link_v[N_STN] && link_w[N_STN].eop;
    assign unused_tail   = ^link_w[N_STN];

    cfg_apply_ctl u_ap (
        .clk(clk), .rst_n(rst_n), .eop_tail(eop_tail), .layer_done(layer_done),
        .go(go), .apply(apply), .cfg_done(cfg_done)
    );
endmodule

// File: rtl/cfg_ring_chk.sv
// Checker: port-level timing rules of the distributor, bound to the top.
module cfg_ring_chk #(
    parameter int unsigned ACT_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_busy,
    input logic             cfg_done,
    input logic             mem_rd_en,
    input logic             apply,
    input logic [ACT_W-1:0] act_cfg
);
    AST_APPLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) apply |=> !apply); // R5
    AST_APPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) apply |-> !cfg_done && !cfg_busy); // R6
    AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !apply |-> $stable(act_cfg)); // R4
    AST_RD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |-> cfg_busy); // R2
    AST_RD_SPACED: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |=> !mem_rd_en); // R2
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cfg_done |-> cfg_busy); // R6
endmodule

bind cfg_ring_dist cfg_ring_chk #(.ACT_W(N_STN*cfg_ring_pkg::N_FLD*cfg_ring_pkg::DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_busy(cfg_busy), .cfg_done(cfg_done),
    .mem_rd_en(mem_rd_en), .apply(apply), .act_cfg(act_cfg)
);

// File: tb/sim_cfg_ring_dist.sv
`timescale 1ns/1ps
module sim_cfg_ring_dist;
    import cfg_ring_pkg::*;
    localparam int NS = 4;
    localparam int AW = 5;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, layer_done = 1'b0;
    logic [AW:0] cfg_len = '0;
    logic cfg_busy, cfg_done, mem_rd_en, apply;
    logic [AW-1:0] mem_rd_addr;
    logic [WORD_W-1:0] rd_data = '0;
    logic [NS-1:0] stn_hold = '0;
    logic [NS*64-1:0] act_cfg;

    logic [WORD_W-1:0] mem [32];
    int rd_cnt = 0;
    int rd_log [64];
    int exp_sh [NS][4];
    int exp_act [NS][4];
    int errors = 0, checks = 0, lat = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cfg_ring_dist #(.N_STN(NS), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
        .cfg_busy(cfg_busy), .cfg_done(cfg_done), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(rd_data), .layer_done(layer_done),
        .stn_hold(stn_hold), .apply(apply), .act_cfg(act_cfg)
    );

    // Buffer model with one-cycle latency and a read log.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            rd_data <= mem[mem_rd_addr];
            if (rd_cnt < 64) rd_log[rd_cnt] = int'(mem_rd_addr);
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(int a, int id, int fld, int data);
        mem[a] = {1'b0, 4'(id), 2'(fld), 16'(data)};
    endtask

    task automatic cmp_act(string req);
        for (int s = 0; s < NS; s++)
            for (int f = 0; f < 4; f++)
                check(req, int'(act_cfg[(s*4+f)*16 +: 16]), exp_act[s][f]);
    endtask

    // Launch a transfer; shadow model follows words in read order.
    task automatic launch(int len);
        for (int a = 0; a < len; a++)
            if (mem[a][21:18] < NS) exp_sh[mem[a][21:18]][mem[a][17:16]] = int'(mem[a][15:0]);
        rd_cnt = 0;
        @(negedge clk);
        cfg_len = (AW+1)'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(string req);
        int k = 0;
        while (!cfg_done && k < 500) begin
            @(negedge clk);
            k++;
        end
        check(req, int'(cfg_done), 1);
    endtask

    task automatic do_layer(string req);
        layer_done = 1'b1;
        @(negedge clk);
        layer_done = 1'b0;
        for (int s = 0; s < NS; s++)
            for (int f = 0; f < 4; f++) exp_act[s][f] = exp_sh[s][f];
        check({req, " apply"}, int'(apply), 1);
        cmp_act(req);
        @(negedge clk);
        check("R5 pulse ends", int'(apply), 0);
    endtask

    task automatic t_reset;
        check("R1 act", int'(|act_cfg), 0);
        check("R1 apply", int'(apply), 0);
        check("R1 busy", int'(cfg_busy), 0);
        check("R1 done", int'(cfg_done), 0);
        check("R1 rd", int'(mem_rd_en), 0);
    endtask

    task automatic load_basic(int base);
        put(0, 0, 0, base + 1);
        put(1, 1, 2, base + 2);
        put(2, 3, 3, base + 3);
        put(3, 2, 1, base + 4);
        put(4, 0, 0, base + 5);
    endtask

    task automatic t_basic;
        int k = 1;
        load_basic(100);
        launch(5);
        check("R6 busy after start", int'(cfg_busy), 1);
        while (!cfg_done && k < 500) begin
            @(negedge clk);
            k++;
        end
        lat = k;
        check("R6 done", int'(cfg_done), 1);
        check("R2 read count", rd_cnt, 5);
        for (int i = 0; i < 5; i++) check("R2 address order", rd_log[i], i);
        repeat (5) @(negedge clk);
        cmp_act("R4 before apply");
        check("R6 done held", int'(cfg_done), 1);
        do_layer("R3");
        check("R6 busy cleared", int'(cfg_busy), 0);
        check("R6 done cleared", int'(cfg_done), 0);
    endtask

    task automatic t_same_cycle;
        bit seen_done = 0;
        load_basic(200);
        for (int a = 0; a < 5; a++)
            if (mem[a][21:18] < NS) exp_sh[mem[a][21:18]][mem[a][17:16]] = int'(mem[a][15:0]);
        @(negedge clk);
        cfg_len = 6'd5;
        start = 1'b1;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (cfg_done) seen_done = 1;
            if (k == lat - 1) layer_done = 1'b1;
            if (k == lat) layer_done = 1'b0;
        end
        for (int s = 0; s < NS; s++)
            for (int f = 0; f < 4; f++) exp_act[s][f] = exp_sh[s][f];
        check("R5 same-cycle apply", int'(apply), 1);
        check("R5 same-cycle no done", int'(seen_done), 0);
        cmp_act("R5 same-cycle values");
    endtask

    task automatic t_layer_first;
        int k = 1;
        @(negedge clk);
        layer_done = 1'b1;
        @(negedge clk);
        layer_done = 1'b0;
        load_basic(300);
        launch(5);
        while (!apply && !cfg_done && k < 500) begin
            @(negedge clk);
            k++;
        end
        for (int s = 0; s < NS; s++)
            for (int f = 0; f < 4; f++) exp_act[s][f] = exp_sh[s][f];
        check("R5 layer-first timing", k, lat);
        check("R5 layer-first apply", int'(apply), 1);
        cmp_act("R5 layer-first values");
    endtask

    task automatic t_hold;
        put(0, 1, 0, 11); put(1, 1, 1, 12); put(2, 2, 2, 13); put(3, 3, 0, 14);
        stn_hold = 4'b0001;
        launch(4);
        repeat (20) @(negedge clk);
        check("R7 reads stop", rd_cnt, 1);
        check("R7 no done under hold", int'(cfg_done), 0);
        stn_hold = 4'b0000;
        wait_done("R7 done after release");
        check("R7 read count", rd_cnt, 4);
        do_layer("R7");
        put(0, 0, 3, 21); put(1, 2, 0, 22); put(2, 3, 1, 23); put(3, 1, 3, 24); put(4, 0, 2, 25);
        launch(5);
        stn_hold = 4'b0100;
        repeat (10) @(negedge clk);
        check("R7 middle hold no done", int'(cfg_done), 0);
        stn_hold = 4'b0000;
        wait_done("R7 done middle");
        check("R7 middle read count", rd_cnt, 5);
        do_layer("R7 middle");
    endtask

    task automatic t_bad_id;
        put(0, 9, 1, 901); put(1, 4, 2, 902); put(2, 2, 3, 903); put(3, 15, 0, 904);
        launch(4);
        wait_done("R8 done");
        do_layer("R8");
    endtask

    task automatic t_busy_start;
        put(0, 3, 2, 31); put(1, 0, 1, 32); put(2, 1, 1, 33);
        put(3, 2, 2, 777); put(4, 2, 3, 778); put(5, 3, 3, 779);
        launch(3);
        @(negedge clk);
        cfg_len = 6'd6;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9 done");
        check("R9 read count", rd_cnt, 3);
        do_layer("R9");
        repeat (3) @(negedge clk);
        check("R9 stays idle", int'(cfg_busy), 0);
    endtask

    task automatic t_zero_len;
        launch(0);
        wait_done("R10 done");
        check("R10 no reads", rd_cnt, 0);
        do_layer("R10");
    endtask

    initial begin
        for (int a = 0; a < 32; a++) mem[a] = '0;
        for (int s = 0; s < NS; s++)
            for (int f = 0; f < 4; f++) begin
                exp_sh[s][f] = 0;
                exp_act[s][f] = 0;
            end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_same_cycle();
        t_layer_first();
        t_hold();
        t_bad_id();
        t_busy_start();
        t_zero_len();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule